// File: doc/BRIEF.md
# SMBus Stuck-Bus Timeout Monitor

This block watches the synchronized SMBus clock and data lines of a slave interface and detects a bus held low for too long in the middle of a transfer. Each line has its own channel with its own enable. An enabled channel counts system clock cycles while its line stays low, a transfer is in progress and the line does not change. When the count reaches the timeout limit, the block emits a single-cycle pulse. The protocol engine takes that pulse as an order to drop to idle and release SDA, so a master that stalls mid-transfer cannot hold the bus forever.

The limit is derived from the system clock frequency and a nominal window of 25 ms: LIMIT = CLK_HZ * TMO_MS / 1000, with a floor of 2. The two enables are intended to be wired from a configuration register: bit 5 drives the SDA channel and bit 4 drives the SCL channel. Both bits reset to 0, so detection is off until software turns it on.

Top module: `smb_stall_watchdog`

## Requirements
- R1: While rst_n is low and on the first clock after its release, tmo_pulse is 0. Both channel counts start from zero and each line's previous sample is taken as high.
- R2: With sda_to_en=1, xfer_active=1 and sda_s held at 0, tmo_pulse goes high after the LIMIT-th consecutive clock edge at which SDA was already low at the preceding edge.
- R3: With scl_to_en=1, xfer_active=1 and scl_s held at 0, the SCL channel produces the same pulse after the same number of edges.
- R4: A channel whose enable is 0 never causes a pulse. For example, SDA stuck low with only scl_to_en=1 gives no pulse.
- R5: Any change of a monitored line restarts that channel's count from zero.
- R6: A channel counts only while xfer_active=1. A clock edge with xfer_active=0 clears both counts.
- R7: Clearing a channel's enable clears its count at the next clock edge. After the enable is set again, a full LIMIT edges are needed before a pulse.
- R8: tmo_pulse is never high on two consecutive cycles. A pulse clears both channel counts, so a bus that stays stuck yields one pulse every LIMIT+1 cycles. Both channels firing on the same edge yield a single pulse.
- R9: LIMIT equals CLK_HZ*TMO_MS/1000 (floor 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_s | input | 1 | Synchronized SMBus clock line |
| sda_s | input | 1 | Synchronized SMBus data line |
| sda_to_en | input | 1 | Enables the SDA channel (configuration bit 5) |
| scl_to_en | input | 1 | Enables the SCL channel (configuration bit 4) |
| xfer_active | input | 1 | High while the protocol engine is inside a transfer |
| tmo_pulse | output | 1 | One-cycle timeout pulse to the protocol engine |

## Verification
The bench builds the block with CLK_HZ=800 and the default 25 ms window, which gives LIMIT=20. With so short a window, a stuck line reaches several back-to-back timeouts within a few dozen cycles. That brings the LIMIT+1 repeat period, coincident firing of both channels, and enable or activity changes falling just before the final count into reach of both directed and random stimulus. The production default of 50 MHz gives a 1.25 M-cycle window and is only elaborated.

// File: rtl/smbto_pkg.sv
package smbto_pkg;

  localparam int unsigned CH_SDA = 0;
  localparam int unsigned CH_SCL = 1;
  localparam int unsigned NCH    = 2;

  // Cycles in the timeout window; never below 2 so the counter is meaningful.
  function automatic int unsigned tmo_limit(int unsigned clk_hz, int unsigned ms);
    longint unsigned t;
    t = (longint'(clk_hz) * longint'(ms)) / 64'd1000;
    if (t < 64'd2) t = 64'd2;
    return int'(t);
  endfunction

  // Counter width able to hold LIMIT-1.
  function automatic int unsigned cnt_width(int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim);
  endfunction

endpackage

// File: rtl/smbto_line_chan.sv
module smbto_line_chan #(
  parameter int unsigned LIMIT = 20,
  parameter int unsigned CW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_i,
  input  logic          en_i,
  input  logic          active_i,
  input  logic          clear_i,
  output logic          hit_o,
  output logic [CW-1:0] cnt_o
);

  logic          line_q;
  logic          line_moved;
  logic          counting;
  logic [CW-1:0] cnt_q;

  // Previous sample of the line; an idle bus is high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b1;
    else        line_q <= line_i;
  end

  assign line_moved = line_i ^ line_q;
  assign counting   = en_i && active_i && !line_i && !line_moved && !clear_i;
  assign hit_o      = counting && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!counting || hit_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/smbto_pulse_merge.sv
module smbto_pulse_merge #(
  parameter int unsigned NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] hit_i,
  output logic           pulse_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_o <= 1'b0;
    else        pulse_o <= |hit_i;
  end

endmodule

// File: rtl/smb_stall_watchdog.sv
module smb_stall_watchdog
  import smbto_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int unsigned TMO_MS = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  input  logic sda_to_en,
  input  logic scl_to_en,
  input  logic xfer_active,
  output logic tmo_pulse
);

  localparam int unsigned LIMIT = tmo_limit(CLK_HZ, TMO_MS);
  localparam int unsigned CW    = cnt_width(LIMIT);

  logic [NCH-1:0] line_w;
  logic [NCH-1:0] en_w;
  logic [NCH-1:0] hit_w;
  logic [CW-1:0]  cnt_w [NCH];

  // Named internal events for the checker.
  logic          sda_hit;
  logic          scl_hit;
  logic [CW-1:0] sda_cnt;
  logic [CW-1:0] scl_cnt;

  assign line_w[CH_SDA] = sda_s;
  assign line_w[CH_SCL] = scl_s;
  assign en_w[CH_SDA]   = sda_to_en;
  assign en_w[CH_SCL]   = scl_to_en;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    smbto_line_chan #(
      .LIMIT (LIMIT),
      .CW    (CW)
    ) chan_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_i   (line_w[g]),
      .en_i     (en_w[g]),
      .active_i (xfer_active),
      .clear_i  (tmo_pulse),
      .hit_o    (hit_w[g]),
      .cnt_o    (cnt_w[g])
    );
  end

  smbto_pulse_merge #(.NCH(NCH)) merge_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit_i   (hit_w),
    .pulse_o (tmo_pulse)
  );

  assign sda_hit = hit_w[CH_SDA];
  assign scl_hit = hit_w[CH_SCL];
  assign sda_cnt = cnt_w[CH_SDA];
  assign scl_cnt = cnt_w[CH_SCL];

endmodule

// File: rtl/smb_stall_watchdog_chk.sv
module smb_stall_watchdog_chk #(
  parameter int unsigned LIMIT = 20,
  parameter int unsigned CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          sda_s,
  input logic          sda_to_en,
  input logic          scl_to_en,
  input logic          xfer_active,
  input logic          tmo_pulse,
  input logic          sda_hit,
  input logic          scl_hit,
  input logic [CW-1:0] sda_cnt,
  input logic [CW-1:0] scl_cnt
);

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !tmo_pulse); // R1
  AST_HIT_GIVES_PULSE: assert property (@(posedge clk) disable iff (!rst_n) (sda_hit || scl_hit) |=> tmo_pulse); // R2
  AST_PULSE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) tmo_pulse |-> $past(sda_hit || scl_hit)); // R2
  AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) (sda_cnt < CW'(LIMIT)) && (scl_cnt < CW'(LIMIT))); // R9
  AST_SCL_HIT_QUAL: assert property (@(posedge clk) disable iff (!rst_n) scl_hit |-> (scl_to_en && !scl_s && xfer_active)); // R3
  AST_SDA_HIT_QUAL: assert property (@(posedge clk) disable iff (!rst_n) sda_hit |-> (sda_to_en && !sda_s && xfer_active)); // R4
  AST_SDA_EDGE_RESTART: assert property (@(posedge clk) disable iff (!rst_n) !$stable(sda_s) |=> (sda_cnt == '0)); // R5
  AST_SCL_EDGE_RESTART: assert property (@(posedge clk) disable iff (!rst_n) !$stable(scl_s) |=> (scl_cnt == '0)); // R5
  AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n) !xfer_active |=> (sda_cnt == '0 && scl_cnt == '0)); // R6
  AST_SDA_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) !sda_to_en |=> (sda_cnt == '0)); // R7
  AST_SCL_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) !scl_to_en |=> (scl_cnt == '0)); // R7
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) tmo_pulse |=> !tmo_pulse); // R8
  AST_PULSE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n) tmo_pulse |=> (sda_cnt == '0 && scl_cnt == '0)); // R8

endmodule

bind smb_stall_watchdog smb_stall_watchdog_chk #(
  .LIMIT (LIMIT),
  .CW    (CW)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .scl_s       (scl_s),
  .sda_s       (sda_s),
  .sda_to_en   (sda_to_en),
  .scl_to_en   (scl_to_en),
  .xfer_active (xfer_active),
  .tmo_pulse   (tmo_pulse),
  .sda_hit     (sda_hit),
  .scl_hit     (scl_hit),
  .sda_cnt     (sda_cnt),
  .scl_cnt     (scl_cnt)
);

// File: tb/smb_stall_watchdog_tb_top.sv
module smb_stall_watchdog_tb_top;

  localparam int unsigned BCLK = 800;
  localparam int unsigned LIM  = (BCLK * 25) / 1000; // R9: 20 edges

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_s = 1'b1, sda_s = 1'b1;
  logic sda_to_en = 1'b0, scl_to_en = 1'b0, xfer_active = 1'b0;
  logic tmo_pulse;

  int checks = 0;
  int fails  = 0;
  int npulse = 0;
  string tag = "R1";

  // Reference state: last sampled lines, run lengths, expected output.
  bit m_prev_sda = 1'b1, m_prev_scl = 1'b1;
  int m_run_sda = 0, m_run_scl = 0;
  bit m_exp = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  smb_stall_watchdog #(.CLK_HZ(BCLK), .TMO_MS(25)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_s       (scl_s),
    .sda_s       (sda_s),
    .sda_to_en   (sda_to_en),
    .scl_to_en   (scl_to_en),
    .xfer_active (xfer_active),
    .tmo_pulse   (tmo_pulse)
  );

  function automatic bit stuck_edge(bit en, bit act, bit line, bit prev, bit pulsing);
    return en && act && (line == 1'b0) && (prev == 1'b0) && !pulsing;
  endfunction

  task automatic check(string req, logic act, logic expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, expv, $time);
    end
  endtask

  // One cycle: check the result of the last edge, then drive the next inputs.
  task automatic step(bit scl, bit sda, bit esda, bit escl, bit act);
    bit q_sda, q_scl, f_sda, f_scl;
    @(negedge clk);
    check(tag, tmo_pulse, m_exp);
    if (tmo_pulse === 1'b1) npulse++;
    scl_s = scl; sda_s = sda; sda_to_en = esda; scl_to_en = escl; xfer_active = act;
    if (!rst_n) begin
      m_prev_sda = 1'b1; m_prev_scl = 1'b1; m_run_sda = 0; m_run_scl = 0; m_exp = 1'b0;
    end else begin
      q_sda = stuck_edge(esda, act, sda, m_prev_sda, m_exp);
      q_scl = stuck_edge(escl, act, scl, m_prev_scl, m_exp);
      m_run_sda = q_sda ? m_run_sda + 1 : 0;
      m_run_scl = q_scl ? m_run_scl + 1 : 0;
      f_sda = (m_run_sda == LIM);
      f_scl = (m_run_scl == LIM);
      if (f_sda) m_run_sda = 0;
      if (f_scl) m_run_scl = 0;
      m_exp = f_sda || f_scl;
      m_prev_sda = sda; m_prev_scl = scl;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic expect_count(string req, int want);
    idle(2);
    checks++;
    if (npulse != want) begin
      fails++;
      $display("FAIL %s pulse count: actual=%0d expected=%0d", req, npulse, want);
    end
    npulse = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    bit r_sda, r_scl, r_esda, r_escl, r_act;
    void'($urandom(32'h1ACE5));

    // R1: reset with the bus stuck and everything enabled
    tag = "R1";
    for (int i = 0; i < 30; i++) step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    @(negedge clk); rst_n = 1'b1;
    check("R1", tmo_pulse, 1'b0);
    idle(3);
    npulse = 0;

    // R2 and R9: SDA stuck 30 edges with only the SDA channel on
    tag = "R2";
    for (int i = 0; i < 30; i++) step(1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    expect_count("R2", 1);

    // R3: SCL stuck
    tag = "R3";
    for (int i = 0; i < 30; i++) step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    expect_count("R3", 1);

    // R4: SDA stuck, only SCL channel enabled
    tag = "R4";
    for (int i = 0; i < 60; i++) step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    expect_count("R4", 0);

    // R5: SDA low with a one-cycle release every 15 cycles
    tag = "R5";
    for (int i = 0; i < 60; i++) step(1'b1, (i % 15) == 14, 1'b1, 1'b1, 1'b1);
    expect_count("R5", 0);

    // R6: transfer flag drops every 18 cycles
    tag = "R6";
    for (int i = 0; i < 72; i++) step(1'b0, 1'b0, 1'b1, 1'b1, (i % 18) != 17);
    expect_count("R6", 0);

    // R7: enable cleared for one cycle mid-count, then full window again
    tag = "R7";
    for (int i = 0; i < 34; i++) step(1'b1, 1'b0, i != 15, 1'b0, 1'b1);
    expect_count("R7", 0);
    for (int i = 0; i < 40; i++) step(1'b1, 1'b0, i != 15, 1'b0, 1'b1);
    expect_count("R7", 1);

    // R8: both lines stuck together; period LIMIT+1, single pulse per firing
    tag = "R8";
    for (int i = 0; i < 70; i++) step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    expect_count("R8", 3);

    // R8: channels offset by one cycle must not stretch the pulse
    for (int i = 0; i < 50; i++) step(i == 0, 1'b0, 1'b1, 1'b1, 1'b1);
    expect_count("R8", 2);

    // Random mix, checked cycle by cycle against the reference
    tag = "R2/R3/R5/R6/R7/R8";
    r_sda = 1'b1; r_scl = 1'b1; r_esda = 1'b1; r_escl = 1'b1; r_act = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(39) == 0) r_sda = ~r_sda;
      if ($urandom_range(39) == 0) r_scl = ~r_scl;
      if ($urandom_range(149) == 0) r_esda = ~r_esda;
      if ($urandom_range(149) == 0) r_escl = ~r_escl;
      if ($urandom_range(99) == 0) r_act = ~r_act;
      step(r_scl, r_sda, r_esda, r_escl, r_act);
    end
    idle(3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule